// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block derives the sixteen-times-oversampling enable for a UART receiver and transmitter from the peripheral clock. One control bit picks how the rate is made. In divide mode a down-counter reloads from the programmed value and pulses once per wrap, so the tick period is a whole number of clocks. In fractional mode a phase accumulator adds the programmed increment on every clock and pulses on each carry out of its top bit. This keeps the average rate accurate to a fraction of a clock at high baud rates.

Software works out the programmed value from the target rate. For divide mode the value is clock / (16 × baud). For fractional mode it is baud × 16 × 2^16 / clock. Divide mode suits rates below 19200 baud and fractional mode suits 19200 and above. For example, a 200 MHz clock needs 1302 for 9600 baud in divide mode and about 604 for 115200 baud in fractional mode. The run enable gates everything. Software drops it before it changes the value or the mode, then raises it again.

Top module: `baud_tick_gen`

## Requirements
- R1: During and right after reset, `tick` is low and both engines hold zero state.
- R2: While `run_en` is low, no tick is produced in either mode, whatever the values of `baud_val` and `mode_sel`.
- R3: In divide mode (`mode_sel` = 0) with value N ≥ 2, the first clock edge at which `run_en` is high loads N. The first tick then follows the (N+1)-th such edge, and later ticks follow every N edges. Over M edges with `run_en` high, the tick count is floor((M−1)/N).
- R4: In divide mode, a value of 0 or 1 behaves as N = 1: a tick follows every edge from the second edge with `run_en` high onward.
- R5: In fractional mode (`mode_sel` = 1) with increment K, the total tick count after M edges with `run_en` high is exactly floor(M·K / 65536).
- R6: In fractional mode, a tick appears exactly when the 16-bit accumulator wraps. When K < 32768, no two ticks are adjacent.
- R7: `mode_sel` = 0 selects the counter and `mode_sel` = 1 selects the accumulator. Only the selected engine runs, and only its tick reaches the output.
- R8: Lowering `run_en` discards all phase. After `run_en` rises again, the tick timing is the same as from a fresh start, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low holds both engines at zero |
| mode_sel | input | 1 | 0 = integer divider, 1 = phase accumulator |
| baud_val | input | 16 | Divider reload value or accumulator increment |
| tick | output | 1 | Oversampling enable pulse, one clock per event |

## Verification
The assertions assume that `mode_sel` and `baud_val` only change while `run_en` is low, as the software sequence requires. The bench always changes them at a falling edge with `run_en` deasserted, or in the same cycle that it raises `run_en`. The accumulator carry assertion depends on the increment staying fixed between two edges. The one-engine-at-a-time assertion depends on the mode gating of each engine's run input. The stimulus never switches mode while running, so both assertions hold throughout.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic {
        BT_MODE_DIV = 1'b0,
        BT_MODE_ACC = 1'b1
    } bt_mode_e;
endpackage

// File: rtl/bt_div_counter.sv
module bt_div_counter #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [VAL_W-1:0] period,
    output logic             tick
);
    localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t          s_d, s_q;
    logic [VAL_W-1:0] eff_d;

    always_comb begin
        // values 0 and 1 both mean "every clock"
        eff_d   = (period <= ONE) ? ONE : period;
        s_d     = s_q;
        s_d.tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == '0) begin
            s_d.cnt = eff_d;              // first edge after run rises
        end else if (s_q.cnt == ONE) begin
            s_d.cnt  = eff_d;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0 && !s_q.tick));

    assert_tick_at_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick |-> ($past(s_q.cnt) == ONE));

    assert_never_zero_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (s_q.cnt != '0));
endmodule

// File: rtl/bt_phase_acc.sv
module bt_phase_acc #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [VAL_W-1:0] incr,
    output logic             tick
);
    typedef struct packed {
        logic [VAL_W-1:0] acc;
        logic             tick;
    } acc_st_t;

    acc_st_t      s_d, s_q;
    logic [VAL_W:0] sum_d;

    always_comb begin
        sum_d = {1'b0, s_q.acc} + {1'b0, incr};
        if (run) begin
            s_d.acc  = sum_d[VAL_W-1:0];
            s_d.tick = sum_d[VAL_W];      // carry out is the tick
        end else begin
            s_d.acc  = '0;
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.acc == '0 && !s_q.tick));

    // a wrap makes the phase smaller, no wrap leaves it equal or larger
    assert_tick_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $stable(incr)) |-> (s_q.tick == (s_q.acc < $past(s_q.acc))));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             mode_sel,
    input  logic [VAL_W-1:0] baud_val,
    output logic             tick
);
    import bt_pkg::*;

    bt_mode_e mode;
    logic     div_run, acc_run;
    logic     div_tick, acc_tick;

    assign mode    = bt_mode_e'(mode_sel);
    assign div_run = run_en && (mode == BT_MODE_DIV);
    assign acc_run = run_en && (mode == BT_MODE_ACC);

    bt_div_counter #(.VAL_W(VAL_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (div_run),
        .period (baud_val),
        .tick   (div_tick)
    );

    bt_phase_acc #(.VAL_W(VAL_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (acc_run),
        .incr  (baud_val),
        .tick  (acc_tick)
    );

    assign tick = (mode == BT_MODE_ACC) ? acc_tick : div_tick;

    assert_one_engine_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div_tick, acc_tick}));

    assert_acc_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_tick |-> $past(mode_sel));

    assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic        mode;
        logic [15:0] val;
        logic [31:0] cyc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd1302,  32'd6000},   // R3 9600 baud at 200 MHz
        '{1'b0, 16'd5,     32'd101},    // R3
        '{1'b0, 16'd0,     32'd40},     // R4
        '{1'b0, 16'd1,     32'd40},     // R4
        '{1'b0, 16'd65535, 32'd100},    // R3 no wrap yet
        '{1'b1, 16'd604,   32'd10000},  // R5 115200 baud
        '{1'b1, 16'd32768, 32'd64},     // R5
        '{1'b1, 16'd65535, 32'd100},    // R5
        '{1'b1, 16'd2,     32'd40000},  // R5
        '{1'b1, 16'd5,     32'd101}     // R7 same value, other mode
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        mode_sel = 1'b0;
    logic [15:0] baud_val = '0;
    logic        tick;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .mode_sel(mode_sel), .baud_val(baud_val), .tick(tick)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint expect_ticks(input logic m, input int v, input longint cyc);
        longint n;
        if (m == 1'b0) begin
            n = (v < 2) ? 1 : v;
            return (cyc - 1) / n;
        end
        return (cyc * v) >> 16;
    endfunction

    task automatic run_window(input logic m, input logic [15:0] v, input int cyc,
                              output int ticks, output int adj);
        logic prev;
        prev = 1'b0; ticks = 0; adj = 0;
        mode_sel = m; baud_val = v; run_en = 1'b1;
        repeat (cyc) begin
            @(negedge clk);
            if (tick) ticks++;
            if (tick && prev) adj++;
            prev = tick;
        end
        run_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic observe(input int n, output logic [15:0] pat);
        pat = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pat[k] = tick;
        end
    endtask

    initial begin
        int t, a, idle;
        logic [15:0] pat;

        repeat (3) @(negedge clk);
        check("R1 tick in reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick after reset", tick, 0);

        for (int i = 0; i < NV; i++) begin
            run_window(VECS[i].mode, VECS[i].val, int'(VECS[i].cyc), t, a);
            check($sformatf("R3/R4/R5/R7 vector %0d tick count", i), t,
                  expect_ticks(VECS[i].mode, int'(VECS[i].val), longint'(VECS[i].cyc)));
            if (VECS[i].mode && VECS[i].val < 16'd32768)
                check($sformatf("R6 vector %0d adjacent ticks", i), a, 0);
        end

        // R3 first tick position for N = 4: after edge 5 only within edges 1..6
        @(negedge clk);
        mode_sel = 1'b0; baud_val = 16'd4; run_en = 1'b1;
        observe(6, pat);
        check("R3 first tick position", pat[5:0], 6'b010000);
        run_en = 1'b0;
        repeat (3) @(negedge clk);

        // R2 idle in both modes
        idle = 0;
        mode_sel = 1'b0; baud_val = 16'd1;
        repeat (20) begin @(negedge clk); if (tick) idle++; end
        mode_sel = 1'b1; baud_val = 16'hFFFF;
        repeat (20) begin @(negedge clk); if (tick) idle++; end
        check("R2 ticks while stopped", idle, 0);

        // R8 accumulator restart: phase from the aborted run must be gone
        mode_sel = 1'b1; baud_val = 16'd40000; run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        observe(2, pat);
        check("R8 accumulator restart pattern", pat[1:0], 2'b10);
        run_en = 1'b0;
        repeat (3) @(negedge clk);

        // R8 counter restart: N = 3, first tick after edge 4
        mode_sel = 1'b0; baud_val = 16'd3; run_en = 1'b1;
        repeat (2) @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        observe(4, pat);
        check("R8 counter restart pattern", pat[3:0], 4'b1000);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 tick low after stop", tick, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule